// File: doc/BRIEF.md
# Scatter-Gather Segment List Walker

This block turns a source description into a stream of (address, length) segments for a downstream data mover. In list mode it reads a table of two-word entries from memory, one word at a time, over a simple request/response port. Entry i sits at the list base plus eight times i. The first word of an entry carries the segment length and an end-of-list flag, and the word four bytes above it carries the segment address. Each decoded entry is offered on a valid/ready segment output before the next entry is fetched.

In direct mode no memory traffic takes place. A single segment is built from the source address and source length inputs, and it is marked as the final one. When the final segment has been taken, the block reports completion with a one-cycle done pulse. A list that runs to the configured entry cap without an end marker ends the walk with an error flag, and that flag remains set until the next start.

Top module: `sgl_walker`

## Requirements
- R1: For entry i the block reads the word at base + 8*i first and then the word at base + 8*i + 4. No other memory addresses are requested.
- R2: A segment's length equals bits [27:0] of the entry's length word. Bits [30:28] of that word have no effect.
- R3: A segment's address equals bits [30:0] of the entry's address word, with bit 31 forced to zero. In direct mode the source address is masked the same way.
- R4: Bit 31 of the length word marks the final entry. That segment is presented with seg_last_o = 1, and no further memory request follows once it has been accepted.
- R5: The block issues no memory request for entry i+1 until the segment for entry i has been accepted (seg_valid_o and seg_ready_i both high), and it never asserts a request while a segment is pending.
- R6: A segment with length zero is still presented and must be accepted like any other segment.
- R7: After MAX_ENTRIES (256) segments have been accepted without an end marker, the walk stops, error_o goes to 1 and done_o pulses.
- R8: With list mode off at start, exactly one segment {source address with bit 31 cleared, source length, last = 1} is produced and no memory request is made.
- R9: done_o is high for exactly one cycle, in the cycle after the final segment is accepted.
- R10: error_o stays at 1 after a capped walk until the next accepted start, which clears it.
- R11: A start pulse that arrives while a walk is in progress is ignored.
- R12: While a memory request or a segment is stalled, it stays asserted and its address and length stay stable.
- R13: After reset, mem_req_valid_o, seg_valid_o, done_o and error_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a walk when the block is idle |
| sg_en_i | input | 1 | 1 = list mode, 0 = direct mode (sampled on start) |
| list_base_i | input | 32 | Byte address of list entry 0 |
| src_addr_i | input | 32 | Direct-mode segment address |
| src_len_i | input | 28 | Direct-mode segment length |
| mem_req_valid_o | output | 1 | Word read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Byte address of the requested word |
| mem_rsp_valid_i | input | 1 | Read data valid, one response per request |
| mem_rsp_data_i | input | 32 | Read data, little-endian word |
| seg_valid_o | output | 1 | Segment valid |
| seg_ready_i | input | 1 | Downstream accepts the segment |
| seg_addr_o | output | 32 | Segment start address |
| seg_len_o | output | 28 | Segment length in bytes |
| seg_last_o | output | 1 | Segment is the final one of the walk |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Entry cap reached without end marker |

## Verification
On every cycle, the assertions check that a memory request and a segment are never offered together, that stalled requests and segments hold still, that done lasts a single cycle, that error rises only together with done, and that no segment address has bit 31 set. Other behaviour depends on sequences that span many cycles, so only the bench scenarios can show it. This covers the address order of the fetches, the field extraction from real table contents, that the walk stops at the end marker, that a zero-length entry is forwarded, that the walk stops at the 256-entry cap, the exact timing of the done pulse, that error persists and is then cleared, and that a start during a walk is ignored.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
    localparam int unsigned WORD_BYTES  = 4;
    localparam int unsigned ENTRY_WORDS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN_REQ,
        ST_LEN_WAIT,
        ST_ADR_REQ,
        ST_ADR_WAIT,
        ST_EMIT
    } sgl_state_e;
endpackage

// File: rtl/sgl_word_fields.sv
module sgl_word_fields #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LEN_W  = 28,
    parameter int unsigned ADDR_W = 32
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [LEN_W-1:0]  len_o,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic unused_flag_bits;

    assign len_o            = word_i[LEN_W-1:0];
    assign last_o           = word_i[DATA_W-1];
    assign addr_o           = {1'b0, word_i[ADDR_W-2:0]};
    assign unused_flag_bits = ^word_i[DATA_W-2:LEN_W];
endmodule

// File: rtl/sgl_ctrl.sv
module sgl_ctrl
    import sgl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned LEN_W       = 28,
    parameter int unsigned MAX_ENTRIES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sg_en_i,
    input  logic [ADDR_W-1:0] list_base_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [LEN_W-1:0]  src_len_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [LEN_W-1:0]  fld_len_i,
    input  logic              fld_last_i,
    input  logic [ADDR_W-1:0] fld_addr_i,
    output logic              seg_valid_o,
    input  logic              seg_ready_i,
    output logic [ADDR_W-1:0] seg_addr_o,
    output logic [LEN_W-1:0]  seg_len_o,
    output logic              seg_last_o,
    output logic              done_o,
    output logic              error_o
);
    localparam int unsigned IDX_W       = $clog2(MAX_ENTRIES);
    localparam int unsigned ENTRY_SHIFT = $clog2(WORD_BYTES * ENTRY_WORDS);
    localparam logic [ADDR_W-1:0] ADDR_KEEP = {1'b0, {(ADDR_W-1){1'b1}}};
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(MAX_ENTRIES - 1);

    typedef struct packed {
        sgl_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] saddr;
        logic [LEN_W-1:0]  slen;
        logic              slast;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_q, r_d;
    logic  seg_take;
    logic [ADDR_W-1:0] entry_ofs;
    logic [ADDR_W-1:0] word_ofs;

    assign seg_take  = (r_q.st == ST_EMIT) && seg_ready_i;
    assign entry_ofs = ADDR_W'(r_q.idx) << ENTRY_SHIFT;
    assign word_ofs  = (r_q.st == ST_ADR_REQ) ? ADDR_W'(WORD_BYTES) : '0;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.err  = 1'b0;
                    r_d.idx  = '0;
                    r_d.base = list_base_i;
                    if (sg_en_i) begin
                        r_d.st = ST_LEN_REQ;
                    end else begin
                        r_d.saddr = src_addr_i & ADDR_KEEP;
                        r_d.slen  = src_len_i;
                        r_d.slast = 1'b1;
                        r_d.st    = ST_EMIT;
                    end
                end
            end
            ST_LEN_REQ:  if (mem_req_ready_i) r_d.st = ST_LEN_WAIT;
            ST_LEN_WAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.slen  = fld_len_i;
                    r_d.slast = fld_last_i;
                    r_d.st    = ST_ADR_REQ;
                end
            end
            ST_ADR_REQ:  if (mem_req_ready_i) r_d.st = ST_ADR_WAIT;
            ST_ADR_WAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.saddr = fld_addr_i;
                    r_d.st    = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (seg_ready_i) begin
                    if (r_q.slast) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else if (r_q.idx == LAST_IDX) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_LEN_REQ;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_req_valid_o = (r_q.st == ST_LEN_REQ) || (r_q.st == ST_ADR_REQ);
    assign mem_req_addr_o  = r_q.base + entry_ofs + word_ofs;
    assign seg_valid_o     = (r_q.st == ST_EMIT);
    assign seg_addr_o      = r_q.saddr;
    assign seg_len_o       = r_q.slen;
    assign seg_last_o      = r_q.slast;
    assign done_o          = r_q.done;
    assign error_o         = r_q.err;

    assert_no_req_during_seg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid_o && seg_valid_o));
    assert_seg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid_o && !seg_ready_i) |=> (seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o) && $stable(seg_last_o)));
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(seg_take));
    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> done_o);
    assert_addr_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid_o |-> !seg_addr_o[ADDR_W-1]);
endmodule

// File: rtl/sgl_walker.sv
module sgl_walker #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned LEN_W       = 28,
    parameter int unsigned MAX_ENTRIES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sg_en_i,
    input  logic [ADDR_W-1:0] list_base_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [LEN_W-1:0]  src_len_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    output logic              seg_valid_o,
    input  logic              seg_ready_i,
    output logic [ADDR_W-1:0] seg_addr_o,
    output logic [LEN_W-1:0]  seg_len_o,
    output logic              seg_last_o,
    output logic              done_o,
    output logic              error_o
);
    logic [LEN_W-1:0]  fld_len;
    logic              fld_last;
    logic [ADDR_W-1:0] fld_addr;

    sgl_word_fields #(.DATA_W(DATA_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) fields_i (
        .word_i (mem_rsp_data_i),
        .len_o  (fld_len),
        .last_o (fld_last),
        .addr_o (fld_addr)
    );

    sgl_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_ENTRIES(MAX_ENTRIES)) ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .sg_en_i         (sg_en_i),
        .list_base_i     (list_base_i),
        .src_addr_i      (src_addr_i),
        .src_len_i       (src_len_i),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_req_addr_o  (mem_req_addr_o),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .fld_len_i       (fld_len),
        .fld_last_i      (fld_last),
        .fld_addr_i      (fld_addr),
        .seg_valid_o     (seg_valid_o),
        .seg_ready_i     (seg_ready_i),
        .seg_addr_o      (seg_addr_o),
        .seg_len_o       (seg_len_o),
        .seg_last_o      (seg_last_o),
        .done_o          (done_o),
        .error_o         (error_o)
    );
endmodule

// File: tb/sgl_walker_tb_top.sv
module sgl_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sg_en_i = 1'b0;
    logic [31:0] list_base_i = '0;
    logic [31:0] src_addr_i = '0;
    logic [27:0] src_len_i = '0;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [31:0] mem_req_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        seg_valid_o;
    logic        seg_ready_i = 1'b0;
    logic [31:0] seg_addr_o;
    logic [27:0] seg_len_o;
    logic        seg_last_o;
    logic        done_o;
    logic        error_o;

    always #4 clk = ~clk;

    sgl_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sg_en_i(sg_en_i),
        .list_base_i(list_base_i), .src_addr_i(src_addr_i), .src_len_i(src_len_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .seg_valid_o(seg_valid_o),
        .seg_ready_i(seg_ready_i), .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o),
        .seg_last_o(seg_last_o), .done_o(done_o), .error_o(error_o)
    );

    logic [31:0] mem [0:4095];
    logic [31:0] rq_log [0:1023];
    logic [31:0] sa_log [0:511];
    logic [27:0] sl_log [0:511];
    logic        st_log [0:511];
    int          rq_at  [0:511];
    int nreq = 0, nseg = 0, ndone = 0, cyc = 0, acc_cyc = 0, done_cyc = 0;
    int n_chk = 0, n_bad = 0;
    bit mem_stall = 0, sink_slow = 0, finished = 0;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (mem_req_valid_o && mem_req_ready_i) begin
                if (nreq < 1024) rq_log[nreq] = mem_req_addr_o;
                nreq++;
            end
            if (seg_valid_o && seg_ready_i) begin
                if (nseg < 512) begin
                    sa_log[nseg] = seg_addr_o; sl_log[nseg] = seg_len_o;
                    st_log[nseg] = seg_last_o; rq_at[nseg] = nreq;
                end
                nseg++;
                acc_cyc = cyc;
            end
            if (done_o) begin ndone++; done_cyc = cyc; end
            mem_rsp_valid_i <= mem_req_valid_o && mem_req_ready_i;
            mem_rsp_data_i  <= mem[mem_req_addr_o[13:2]];
            mem_req_ready_i <= mem_stall ? ~mem_req_ready_i : 1'b1;
            seg_ready_i     <= sink_slow ? ~seg_ready_i : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        nreq = 0; nseg = 0; ndone = 0;
    endtask

    task automatic launch(input logic sg, input logic [31:0] base, input logic [31:0] sa, input logic [27:0] sl);
        @(negedge clk);
        sg_en_i = sg; list_base_i = base; src_addr_i = sa; src_len_i = sl; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (ndone == 0 && t < 20000) begin @(negedge clk); t++; end
        chk(ndone != 0, "R9 walk completes", ndone, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_list(input logic [31:0] base, input string tag);
        int n = 0;
        bit fin = 0;
        bit ok = 1;
        while (!fin && n < 256) begin
            logic [31:0] lw = mem[(base + 32'(8 * n)) >> 2];
            logic [31:0] aw = mem[(base + 32'(8 * n) + 32'd4) >> 2];
            chk(rq_log[2*n] == base + 32'(8 * n), {tag, " R1 length word addr"}, rq_log[2*n], base + 32'(8 * n));
            chk(rq_log[2*n+1] == base + 32'(8 * n) + 32'd4, {tag, " R1 address word addr"}, rq_log[2*n+1], base + 32'(8 * n) + 32'd4);
            if (sl_log[n] != lw[27:0]) begin ok = 0; chk(0, {tag, " R2 length"}, 32'(sl_log[n]), 32'(lw[27:0])); end
            if (sa_log[n] != (aw & 32'h7FFF_FFFF)) begin ok = 0; chk(0, {tag, " R3 address"}, sa_log[n], aw & 32'h7FFF_FFFF); end
            if (st_log[n] != lw[31]) begin ok = 0; chk(0, {tag, " R4 last flag"}, 32'(st_log[n]), 32'(lw[31])); end
            if (rq_at[n] != 2 * (n + 1)) begin ok = 0; chk(0, {tag, " R5 no early fetch"}, rq_at[n], 2 * (n + 1)); end
            fin = lw[31];
            n++;
        end
        chk(ok, {tag, " R2 R3 R4 R5 segment fields"}, 32'(ok), 1);
        chk(nseg == n, {tag, " R4 R7 segment count"}, nseg, n);
        chk(nreq == 2 * n, {tag, " R4 R1 request count"}, nreq, 2 * n);
        chk(error_o == !fin, {tag, " R7 error flag"}, 32'(error_o), 32'(!fin));
        chk(ndone == 1, {tag, " R9 one done pulse"}, ndone, 1);
        chk(done_cyc == acc_cyc + 1, {tag, " R9 done timing"}, done_cyc, acc_cyc + 1);
    endtask

    task automatic t_reset();
        chk(!mem_req_valid_o, "R13 req after reset", 32'(mem_req_valid_o), 0);
        chk(!seg_valid_o, "R13 seg after reset", 32'(seg_valid_o), 0);
        chk(!done_o, "R13 done after reset", 32'(done_o), 0);
        chk(!error_o, "R13 error after reset", 32'(error_o), 0);
    endtask

    task automatic t_basic_stall();
        mem_stall = 1; sink_slow = 0; clear_log();
        launch(1'b1, 32'h100, 32'h0, 28'h0);
        repeat (3) @(negedge clk);
        start_i = 1'b1; list_base_i = 32'h400; sg_en_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check_list(32'h100, "basic R11");
    endtask

    task automatic t_zero_backpressure();
        mem_stall = 0; sink_slow = 1; clear_log();
        launch(1'b1, 32'h200, 32'h0, 28'h0);
        wait_done();
        check_list(32'h200, "zero R6 R12");
        chk(sl_log[0] == 28'h0, "R6 zero length forwarded", 32'(sl_log[0]), 0);
    endtask

    task automatic t_direct();
        mem_stall = 0; sink_slow = 1; clear_log();
        launch(1'b0, 32'h100, 32'hC000_5678, 28'h0AB_CDEF);
        wait_done();
        chk(nseg == 1, "R8 one segment", nseg, 1);
        chk(nreq == 0, "R8 no memory traffic", nreq, 0);
        chk(sa_log[0] == 32'h4000_5678, "R8 R3 direct address", sa_log[0], 32'h4000_5678);
        chk(sl_log[0] == 28'h0AB_CDEF, "R8 direct length", 32'(sl_log[0]), 32'h0AB_CDEF);
        chk(st_log[0] == 1'b1, "R8 direct last", 32'(st_log[0]), 1);
        chk(done_cyc == acc_cyc + 1, "R9 direct done timing", done_cyc, acc_cyc + 1);
    endtask

    task automatic t_cap();
        mem_stall = 0; sink_slow = 0; clear_log();
        launch(1'b1, 32'h1000, 32'h0, 28'h0);
        wait_done();
        check_list(32'h1000, "cap R7");
        chk(nseg == 256, "R7 stops at cap", nseg, 256);
        chk(error_o == 1'b1, "R7 error set", 32'(error_o), 1);
    endtask

    task automatic t_error_hold();
        repeat (10) @(negedge clk);
        chk(error_o == 1'b1, "R10 error persists", 32'(error_o), 1);
        clear_log();
        launch(1'b0, 32'h0, 32'h40, 28'h8);
        chk(error_o == 1'b0, "R10 start clears error", 32'(error_o), 0);
        wait_done();
        chk(error_o == 1'b0, "R10 error stays clear", 32'(error_o), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[32'h100 >> 2] = 32'h7000_0040; mem[32'h104 >> 2] = 32'h8000_1234;
        mem[32'h108 >> 2] = 32'h0000_0100; mem[32'h10C >> 2] = 32'h0000_2000;
        mem[32'h110 >> 2] = 32'h8FFF_FFFF; mem[32'h114 >> 2] = 32'hFFFF_FFF0;
        mem[32'h400 >> 2] = 32'h8000_0005; mem[32'h404 >> 2] = 32'h0000_0900;
        mem[32'h200 >> 2] = 32'h0000_0000; mem[32'h204 >> 2] = 32'h0000_0010;
        mem[32'h208 >> 2] = 32'h8000_0003; mem[32'h20C >> 2] = 32'h0000_0020;
        for (int i = 0; i < 256; i++) begin
            mem[(32'h1000 + 32'(8 * i)) >> 2]       = 32'h1000_0000 | 32'(i);
            mem[(32'h1000 + 32'(8 * i) + 4) >> 2]   = 32'h8000_0000 | 32'(i << 4);
        end
        mem[32'h1800 >> 2] = 32'h8000_0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_stall();
        t_zero_backpressure();
        t_direct();
        t_cap();
        t_error_hold();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule